// File: doc/BRIEF.md
# Watermark-Flagged Byte FIFO Pair

This block holds two byte queues between a host microcontroller and a radio datapath. The transmit queue is filled by the host and drained by the radio side. The receive queue is filled by the radio side and drained by the host. Each queue tracks how many bytes it holds and compares that count against programmable 6-bit watermarks. There is one rising watermark on the receive queue. The transmit queue has one rising watermark and one falling watermark.

Each watermark crossing, and each rejected write or read, latches a bit in a status word. The host reads the status word through a single read strobe, and that read clears the latched bits. A per-source enable mask decides which latched bits pull the shared active-low interrupt line. The mask never alters the status word itself. Each queue can be flushed on its own with a one-cycle clear strobe.

Status bit positions are fixed: bit 0 is transmit almost-full, bit 1 is transmit almost-empty, bit 2 is receive almost-full, bit 3 is transmit overflow, bit 4 is transmit underflow, bit 5 is receive overflow, and bit 6 is receive underflow. Threshold selector codes on `cfg_sel` are fixed: 0 selects transmit almost-full, 1 selects transmit almost-empty, and 2 selects receive almost-full.

Top module: `thr_fifo_irq`

## Requirements
- R1: After reset, both levels are 0, the status word is 0 and `irq_n` is 1. The thresholds reset to 55 (0x37) for transmit almost-full, 4 for transmit almost-empty and 55 for receive almost-full.
- R2: Each queue returns bytes in the order they were accepted. The head byte is visible on the read data port before the pop. Each level output counts accepted bytes, up to 64.
- R3: A write to a queue holding 64 bytes is dropped and leaves the level at 64. It sets that queue's overflow bit (3 or 5) at the same clock edge. A pop from an empty queue changes nothing and sets that queue's underflow bit (4 or 6) at the same clock edge.
- R4: A clear strobe empties only its own queue in one cycle. A write presented in the same cycle is discarded, and the clear does not set an overflow bit.
- R5: An almost-full bit (0 or 2) is set one cycle after the level rises from below its threshold to at or above it. It does not set again while the level stays at or above the threshold.
- R6: The transmit almost-empty bit (1) is set one cycle after the transmit level falls from above its threshold to at or below it. Filling the queue never sets it.
- R7: Status bits stay set until a clock edge with `stat_rd` high, which clears them. If a source sets in the same cycle as that read, the set wins.
- R8: With a source's `irq_en` bit at 0, its status bit still sets and reads back, but that source does not pull `irq_n` low.
- R9: `irq_n` is 0 exactly when some status bit and its matching enable bit are both 1. It follows a change of `irq_en` in the same cycle.
- R10: A write with `cfg_we` high loads `cfg_thr` into the threshold that `cfg_sel` picks. The new value governs later crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 2 | Threshold select (0 tx full, 1 tx empty, 2 rx full) |
| cfg_thr | input | 6 | Threshold value to load |
| tx_clr | input | 1 | Flush transmit queue |
| rx_clr | input | 1 | Flush receive queue |
| host_tx_we | input | 1 | Host push into transmit queue |
| host_tx_data | input | 8 | Byte pushed by host |
| radio_tx_re | input | 1 | Radio-side pop from transmit queue |
| radio_tx_data | output | 8 | Transmit queue head byte |
| radio_rx_we | input | 1 | Radio-side push into receive queue |
| radio_rx_data | input | 8 | Byte pushed by radio side |
| host_rx_re | input | 1 | Host pop from receive queue |
| host_rx_data | output | 8 | Receive queue head byte |
| tx_level | output | 7 | Transmit queue occupancy |
| rx_level | output | 7 | Receive queue occupancy |
| irq_en | input | 7 | Per-source interrupt enable |
| stat_rd | input | 1 | Status read strobe, clears latched bits |
| stat | output | 7 | Latched status word |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
A status read can land on the same clock edge as a new watermark crossing. That pits the read-clear against a set of the same bit. The bench primes the receive queue one byte short of its threshold. It pushes the last byte and then raises `stat_rd` on the very edge where the crossing is registered. The returned word must show the bit clear, and the word afterwards must show it set. A second coincidence is a clear strobe together with a write to the same queue. The level must read 0 and the dropped byte must never reach the scoreboard.

// File: rtl/thr_fifo_pkg.sv
package thr_fifo_pkg;
   localparam int SRC_N = 7;

   typedef enum logic [2:0] {
      SRC_TX_AF  = 3'd0,
      SRC_TX_AE  = 3'd1,
      SRC_RX_AF  = 3'd2,
      SRC_TX_OVF = 3'd3,
      SRC_TX_UDF = 3'd4,
      SRC_RX_OVF = 3'd5,
      SRC_RX_UDF = 3'd6
   } src_e;

   typedef enum logic [1:0] {
      SEL_TX_AF = 2'd0,
      SEL_TX_AE = 2'd1,
      SEL_RX_AF = 2'd2
   } thr_sel_e;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
   parameter int DW = 8,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [AW:0]   count,
   output logic          ovf_evt,
   output logic          udf_evt
);
   localparam int DEPTH = 1 << AW;
   localparam int CW    = AW + 1;

   generate
      if (DW < 1 || AW < 1 || AW > 10) begin : g_bad_param
         $error("byte_fifo: DW must be >= 1 and AW within 1..10");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          full, empty, do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full & ~clr;
   assign do_pop  = pop & ~empty & ~clr;
   assign ovf_evt = push & full & ~clr;
   assign udf_evt = pop & empty & ~clr;
   assign rdata   = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (count == CW'(DEPTH)));
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/wmark_det.sv
module wmark_det #(
   parameter int  TW    = 6,
   parameter bit  ABOVE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [TW:0] count,
   input  logic [TW-1:0] thr,
   output logic        hit
);
   localparam int CW = TW + 1;

   generate
      if (TW < 1) begin : g_bad_param
         $error("wmark_det: TW must be >= 1");
      end
   endgenerate

   logic lvl, lvl_q;

   generate
      if (ABOVE) begin : g_rise
         assign lvl = (count >= CW'(thr));
      end else begin : g_fall
         assign lvl = (count <= CW'(thr));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b1;
      else        lvl_q <= lvl;
   end

   assign hit = lvl & ~lvl_q;

   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);
endmodule

// File: rtl/irq_status.sv
module irq_status #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         rd,
   input  logic [N-1:0] en,
   output logic [N-1:0] stat,
   output logic         irq_n
);
   generate
      if (N < 1) begin : g_bad_param
         $error("irq_status: N must be >= 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)  stat <= '0;
      else if (rd) stat <= set;
      else         stat <= stat | set;
   end

   assign irq_n = ~|(stat & en);

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> ((stat & $past(stat)) == $past(stat)));
   assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && set == '0) |=> (stat == '0));
   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((stat & $past(set)) == $past(set)));
   assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> irq_n);
endmodule

// File: rtl/thr_fifo_irq.sv
module thr_fifo_irq
   import thr_fifo_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          AW        = 6,
   parameter logic [AW-1:0] TX_AF_RST = 6'h37,
   parameter logic [AW-1:0] TX_AE_RST = 6'h04,
   parameter logic [AW-1:0] RX_AF_RST = 6'h37
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [AW-1:0]    cfg_thr,
   input  logic             tx_clr,
   input  logic             rx_clr,
   input  logic             host_tx_we,
   input  logic [DW-1:0]    host_tx_data,
   input  logic             radio_tx_re,
   output logic [DW-1:0]    radio_tx_data,
   input  logic             radio_rx_we,
   input  logic [DW-1:0]    radio_rx_data,
   input  logic             host_rx_re,
   output logic [DW-1:0]    host_rx_data,
   output logic [AW:0]      tx_level,
   output logic [AW:0]      rx_level,
   input  logic [SRC_N-1:0] irq_en,
   input  logic             stat_rd,
   output logic [SRC_N-1:0] stat,
   output logic             irq_n
);
   generate
      if (AW < 2) begin : g_bad_param
         $error("thr_fifo_irq: AW must be >= 2");
      end
   endgenerate

   logic [AW-1:0]    thr_tx_af, thr_tx_ae, thr_rx_af;
   logic [SRC_N-1:0] set_vec;
   logic             tx_ovf, tx_udf, rx_ovf, rx_udf;
   logic             tx_af_hit, tx_ae_hit, rx_af_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_tx_af <= TX_AF_RST;
         thr_tx_ae <= TX_AE_RST;
         thr_rx_af <= RX_AF_RST;
      end else if (cfg_we) begin
         case (thr_sel_e'(cfg_sel))
            SEL_TX_AF: thr_tx_af <= cfg_thr;
            SEL_TX_AE: thr_tx_ae <= cfg_thr;
            SEL_RX_AF: thr_rx_af <= cfg_thr;
            default:   ;
         endcase
      end
   end

   byte_fifo #(.DW(DW), .AW(AW)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr),
      .push(host_tx_we), .wdata(host_tx_data),
      .pop(radio_tx_re), .rdata(radio_tx_data),
      .count(tx_level), .ovf_evt(tx_ovf), .udf_evt(tx_udf));

   byte_fifo #(.DW(DW), .AW(AW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr),
      .push(radio_rx_we), .wdata(radio_rx_data),
      .pop(host_rx_re), .rdata(host_rx_data),
      .count(rx_level), .ovf_evt(rx_ovf), .udf_evt(rx_udf));

   wmark_det #(.TW(AW), .ABOVE(1'b1)) u_tx_af (
      .clk(clk), .rst_n(rst_n), .count(tx_level), .thr(thr_tx_af), .hit(tx_af_hit));
   wmark_det #(.TW(AW), .ABOVE(1'b0)) u_tx_ae (
      .clk(clk), .rst_n(rst_n), .count(tx_level), .thr(thr_tx_ae), .hit(tx_ae_hit));
   wmark_det #(.TW(AW), .ABOVE(1'b1)) u_rx_af (
      .clk(clk), .rst_n(rst_n), .count(rx_level), .thr(thr_rx_af), .hit(rx_af_hit));

   always_comb begin
      set_vec             = '0;
      set_vec[SRC_TX_AF]  = tx_af_hit;
      set_vec[SRC_TX_AE]  = tx_ae_hit;
      set_vec[SRC_RX_AF]  = rx_af_hit;
      set_vec[SRC_TX_OVF] = tx_ovf;
      set_vec[SRC_TX_UDF] = tx_udf;
      set_vec[SRC_RX_OVF] = rx_ovf;
      set_vec[SRC_RX_UDF] = rx_udf;
   end

   irq_status #(.N(SRC_N)) u_stat (
      .clk(clk), .rst_n(rst_n), .set(set_vec), .rd(stat_rd),
      .en(irq_en), .stat(stat), .irq_n(irq_n));

   assert_clear_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_clr && !tx_clr && !host_tx_we && !radio_tx_re) |=> (tx_level == $past(tx_level)));
   assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf) |=> stat[SRC_TX_OVF]);
endmodule

// File: tb/sim_thr_fifo_irq.sv
module sim_thr_fifo_irq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_sel = '0;
   logic [5:0] cfg_thr = '0;
   logic       tx_clr = 1'b0, rx_clr = 1'b0;
   logic       host_tx_we = 1'b0, radio_tx_re = 1'b0;
   logic       radio_rx_we = 1'b0, host_rx_re = 1'b0;
   logic [7:0] host_tx_data = '0, radio_rx_data = '0;
   logic [7:0] radio_tx_data, host_rx_data;
   logic [6:0] tx_level, rx_level;
   logic [6:0] irq_en = '0;
   logic       stat_rd = 1'b0;
   logic [6:0] stat;
   logic       irq_n;

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] txq[$];
   logic [7:0] rxq[$];

   always #2 clk = ~clk;

   thr_fifo_irq u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_thr(cfg_thr),
      .tx_clr(tx_clr), .rx_clr(rx_clr),
      .host_tx_we(host_tx_we), .host_tx_data(host_tx_data),
      .radio_tx_re(radio_tx_re), .radio_tx_data(radio_tx_data),
      .radio_rx_we(radio_rx_we), .radio_rx_data(radio_rx_data),
      .host_rx_re(host_rx_re), .host_rx_data(host_rx_data),
      .tx_level(tx_level), .rx_level(rx_level),
      .irq_en(irq_en), .stat_rd(stat_rd), .stat(stat), .irq_n(irq_n));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // scoreboard monitors: compare head byte against the model queue on every pop
   always @(posedge clk) begin
      if (rst_n && radio_tx_re && !tx_clr && txq.size() > 0) chk("R2 tx order", radio_tx_data, txq.pop_front());
      if (rst_n && host_rx_re && !rx_clr && rxq.size() > 0) chk("R2 rx order", host_rx_data, rxq.pop_front());
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic tx_push(input logic [7:0] b);
      host_tx_we = 1'b1; host_tx_data = b;
      if (txq.size() < 64) txq.push_back(b);
      step();
      host_tx_we = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      radio_rx_we = 1'b1; radio_rx_data = b;
      if (rxq.size() < 64) rxq.push_back(b);
      step();
      radio_rx_we = 1'b0;
   endtask

   task automatic tx_pop();
      radio_tx_re = 1'b1; step(); radio_tx_re = 1'b0;
   endtask

   task automatic rx_pop();
      host_rx_re = 1'b1; step(); host_rx_re = 1'b0;
   endtask

   task automatic read_stat(output logic [6:0] v);
      v = stat; stat_rd = 1'b1; step(); stat_rd = 1'b0;
   endtask

   task automatic set_thr(input logic [1:0] s, input logic [5:0] v);
      cfg_we = 1'b1; cfg_sel = s; cfg_thr = v; step(); cfg_we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [6:0] v;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk("R1 tx level", tx_level, 0);
      chk("R1 rx level", rx_level, 0);
      chk("R1 status", stat, 0);
      chk("R1 irq", irq_n, 1);

      // fill transmit to default almost-full threshold 55
      for (int i = 0; i < 54; i++) tx_push(8'(i));
      step();
      chk("R5 below thr", stat[0], 0);
      tx_push(8'd54);
      chk("R5 one-cycle latency", stat[0], 0);
      step();
      chk("R1 default tx af 55", stat[0], 1);
      chk("R8 masked irq", irq_n, 1);
      chk("R6 no ae on fill", stat[1], 0);
      irq_en = 7'b0000001; #1;
      chk("R9 irq follows enable", irq_n, 0);
      read_stat(v);
      chk("R7 read value", v, 7'b0000001);
      chk("R7 cleared", stat, 0);
      chk("R9 irq released", irq_n, 1);
      irq_en = '0;

      for (int i = 55; i < 64; i++) tx_push(8'(i));
      chk("R2 level 64", tx_level, 64);
      tx_push(8'hEE);
      chk("R3 overflow flag", stat[3], 1);
      chk("R3 level held", tx_level, 64);
      chk("R5 no repeat af", stat[0], 0);
      irq_en = 7'b0001000; #1;
      chk("R9 ovf irq", irq_n, 0);
      read_stat(v);
      irq_en = '0;

      for (int i = 0; i < 59; i++) tx_pop();
      step();
      chk("R6 above ae thr", stat[1], 0);
      tx_pop();
      chk("R6 latency", stat[1], 0);
      step();
      chk("R6 ae set at 4", stat[1], 1);
      for (int i = 0; i < 4; i++) tx_pop();
      chk("R2 drained", tx_level, 0);
      tx_pop();
      chk("R3 underflow flag", stat[4], 1);
      chk("R3 level stays 0", tx_level, 0);
      read_stat(v);

      // receive threshold reprogrammed to 3
      set_thr(2'd2, 6'd3);
      rx_push(8'hA1); rx_push(8'hA2);
      step();
      chk("R10 below new thr", stat[2], 0);
      rx_push(8'hA3);
      step();
      chk("R10 new thr governs", stat[2], 1);
      read_stat(v);
      for (int i = 0; i < 3; i++) rx_pop();
      chk("R2 rx drained", rx_level, 0);

      // coincidence: read strobe on the edge the crossing registers
      rx_push(8'hB1); rx_push(8'hB2); rx_push(8'hB3);
      read_stat(v);
      chk("R7 read before set", v[2], 0);
      chk("R7 set wins", stat[2], 1);
      read_stat(v);

      // independent clear with a concurrent write
      tx_push(8'h5A);
      rx_clr = 1'b1; radio_rx_we = 1'b1; radio_rx_data = 8'h77;
      rxq.delete();
      step();
      rx_clr = 1'b0; radio_rx_we = 1'b0;
      chk("R4 rx emptied", rx_level, 0);
      chk("R4 tx untouched", tx_level, 1);
      chk("R4 no ovf from clear", stat[5], 0);
      rx_push(8'h33);
      chk("R4 write dropped", rx_level, 1);
      rx_pop();
      tx_clr = 1'b1; txq.delete(); step(); tx_clr = 1'b0;
      chk("R4 tx emptied", tx_level, 0);
      read_stat(v);

      // masking: status still sets, irq held high
      set_thr(2'd2, 6'd1);
      irq_en = 7'b1111011;
      rx_push(8'h44);
      step();
      chk("R8 status still set", stat[2], 1);
      chk("R8 irq stays high", irq_n, 1);
      irq_en = 7'b0000100; #1;
      chk("R9 irq on enable", irq_n, 0);
      rx_pop();

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule